// File: doc/BRIEF.md
# Clock Synthesizer Serial Programmer

This block loads a location address and a program word into an external frequency synthesizer. The synthesizer is reached through an 8-bit control port. Three lines of that port carry the transfer: a data line, a bit clock and a strobe. A pulse on `start` launches a fixed, timed sequence, and the caller never has to pace the port itself.

The sequence runs in this order:
- Blank the display and hold the port at zero for a long settling wait.
- Issue two framing strobes.
- Shift out a 21-bit frame, least significant bit first, with a two-phase bit clock.
- Wait again, then release blanking and restore the control value that was present at start, with the strobe line held high.
- After a final long wait, leave the low four location bits on the port, again with the strobe high.

Every delay is a cycle count. The block derives each count from the clock frequency and a microsecond figure, all of them parameters. Computing the program word is the job of other logic.

Top module: `clksyn_prog`

## Requirements
- R1: After reset, `ctl_out` is 0, `blank_req` is 0 and `done` is 0.
- R2: A `start` accepted in idle makes `blank_req` 1 and `ctl_out` 0 from the next cycle. Both hold, with no strobe, for BLANK_CYC + SETTLE_CYC cycles before the first strobe.
- R3: While `blank_req` is 1, a strobe is `ctl_out[6]` high for exactly one cycle. Before each strobe, the other bits of `ctl_out` hold the strobed value for exactly SETTLE_CYC cycles (BLANK_CYC + SETTLE_CYC for the first strobe).
- R4: The first two strobes carry the values 8'h00 and 8'h01.
- R5: The frame holds 21 bits, each sent least significant first in its group: first 1, 0, 0 (the last of these is the write flag), then the 5 bits of `loc_addr`, then the 13 bits of `prog_word`.
- R6: Each frame bit takes two strobes. The first carries 8'h01 with bit 2 = data and bit 3 (bit clock) = 0. The second carries the same value with bit 3 = 1.
- R7: After the 44th strobe, `ctl_out` keeps the last value with the strobe clear, and `blank_req` stays 1, for POST_CYC cycles.
- R8: `blank_req` then falls. `ctl_out` then equals the `ctl_in` value captured when start was accepted, OR 8'h40, for FINAL_CYC cycles. Later changes on `ctl_in` have no effect.
- R9: Next, `ctl_out` becomes {4'b0, loc_addr[3:0]} OR 8'h40 and holds that value in idle. `done` is 1 for exactly one cycle, in the first cycle of that value.
- R10: A `start` while the sequence is running is ignored. Its address, word and `ctl_in` do not alter the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch request, taken only when idle |
| loc_addr | input | 5 | Synthesizer location address |
| prog_word | input | 13 | Synthesizer program word |
| ctl_in | input | 8 | Current control-port value, captured at launch |
| ctl_out | output | 8 | Control-port value (bit 2 data, bit 3 bit clock, bit 6 strobe) |
| blank_req | output | 1 | Display blanking request |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench builds the block with CLK_HZ = 1 MHz and waits of 40, 3, 10 and 20 microseconds. Each microsecond figure therefore equals its cycle count, and a whole sequence fits in about 250 cycles. At these values, every cycle of every wait and every one of the 44 strobes can be compared against a trace the bench predicts. The test runs many frames, including all-zero and all-one words and addresses, and injects a start while the block is busy.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BLANK,
    ST_SETTLE,
    ST_STRB,
    ST_POST,
    ST_FINAL
  } clksyn_state_t;

  // cycles for a delay in microseconds, never less than one
  function automatic int us_to_cyc(input longint hz, input longint us);
    longint c;
    c = (hz * us) / 64'd1000000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/clksyn_timer.sv
module clksyn_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/clksyn_frame.sv
module clksyn_frame #(
  parameter int LOC_W    = 5,
  parameter int WORD_W   = 13,
  parameter int CTL_W    = 8,
  parameter int DATA_BIT = 2,
  parameter int CLK_BIT  = 3,
  parameter int IDX_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LOC_W-1:0]  loc,
  input  logic [WORD_W-1:0] word,
  input  logic [IDX_W-1:0]  idx,
  output logic [CTL_W-1:0]  val
);
  localparam int FB = 3 + LOC_W + WORD_W;

  logic [FB-1:0] vec_q;

  // preamble 1,0,0 sits in the low bits and goes out first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    vec_q <= '0;
    else if (load) vec_q <= {word, loc, 3'b001};
  end

  // port value for strobe step i: step 0 -> 0, step 1 -> 1,
  // then two steps per frame bit (clock low, clock high)
  function automatic logic [CTL_W-1:0] step_ctl(input logic [IDX_W-1:0] i,
                                                input logic [FB-1:0] v);
    logic [CTL_W-1:0] r;
    logic [FB-1:0]    sh;
    int               j;
    r = '0;
    if (i != '0) begin
      r[0] = 1'b1;
      if (int'(i) >= 2) begin
        j  = int'(i) - 2;
        sh = v >> (j >> 1);
        r[DATA_BIT] = sh[0];
        r[CLK_BIT]  = j[0];
      end
    end
    return r;
  endfunction

  assign val = step_ctl(idx, vec_q);
endmodule

// File: rtl/clksyn_prog.sv
module clksyn_prog
  import clksyn_pkg::*;
#(
  parameter int     LOC_W     = 5,
  parameter int     WORD_W    = 13,
  parameter int     CTL_W     = 8,
  parameter int     SEL_W     = 4,
  parameter int     DATA_BIT  = 2,
  parameter int     CLK_BIT   = 3,
  parameter int     STB_BIT   = 6,
  parameter longint CLK_HZ    = 125000000,
  parameter longint BLANK_US  = 15000,
  parameter longint SETTLE_US = 26,
  parameter longint POST_US   = 1000,
  parameter longint FINAL_US  = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LOC_W-1:0]  loc_addr,
  input  logic [WORD_W-1:0] prog_word,
  input  logic [CTL_W-1:0]  ctl_in,
  output logic [CTL_W-1:0]  ctl_out,
  output logic              blank_req,
  output logic              done
);
  localparam int FRAME_BITS = 3 + LOC_W + WORD_W;
  localparam int NSTEP      = 2 + 2 * FRAME_BITS;
  localparam int IDX_W      = $clog2(NSTEP + 1);
  localparam int BLANK_CYC  = us_to_cyc(CLK_HZ, BLANK_US);
  localparam int SETTLE_CYC = us_to_cyc(CLK_HZ, SETTLE_US);
  localparam int POST_CYC   = us_to_cyc(CLK_HZ, POST_US);
  localparam int FINAL_CYC  = us_to_cyc(CLK_HZ, FINAL_US);
  localparam int MAX_CYC    = max4(BLANK_CYC, SETTLE_CYC, POST_CYC, FINAL_CYC);
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] BLANK_LD  = CNT_W'(BLANK_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] POST_LD   = CNT_W'(POST_CYC - 1);
  localparam logic [CNT_W-1:0] FINAL_LD  = CNT_W'(FINAL_CYC - 1);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NSTEP - 1);
  localparam logic [CTL_W-1:0] STB_MASK  = CTL_W'(1) << STB_BIT;

  clksyn_state_t    st_q;
  logic [IDX_W-1:0] step_q;
  logic [IDX_W-1:0] step_idx;
  logic [CTL_W-1:0] step_val;
  logic [CTL_W-1:0] orig_q;
  logic [SEL_W-1:0] sel_q;
  logic             t_load;
  logic [CNT_W-1:0] t_val;
  logic             t_zero;

  // named events for the checker
  logic start_acc;
  logic busy_w;
  assign busy_w    = (st_q != ST_IDLE);
  assign start_acc = start && !busy_w;

  // in the strobe cycle, look one step ahead
  assign step_idx = (st_q == ST_STRB) ? step_q + 1'b1 : step_q;

  clksyn_frame #(
    .LOC_W(LOC_W), .WORD_W(WORD_W), .CTL_W(CTL_W),
    .DATA_BIT(DATA_BIT), .CLK_BIT(CLK_BIT), .IDX_W(IDX_W)
  ) u_frame (
    .clk(clk), .rst_n(rst_n), .load(start_acc),
    .loc(loc_addr), .word(prog_word), .idx(step_idx), .val(step_val)
  );

  clksyn_timer #(.CW(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_zero)
  );

  always_comb begin
    t_load = 1'b0;
    t_val  = SETTLE_LD;
    unique case (st_q)
      ST_IDLE:   if (start_acc) begin t_load = 1'b1; t_val = BLANK_LD; end
      ST_BLANK:  if (t_zero)    begin t_load = 1'b1; t_val = SETTLE_LD; end
      ST_STRB:   begin
                   t_load = 1'b1;
                   t_val  = (step_q == LAST_IDX) ? POST_LD : SETTLE_LD;
                 end
      ST_POST:   if (t_zero)    begin t_load = 1'b1; t_val = FINAL_LD; end
      default:   ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      step_q    <= '0;
      orig_q    <= '0;
      sel_q     <= '0;
      ctl_out   <= '0;
      blank_req <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_acc) begin
          orig_q    <= ctl_in;
          sel_q     <= loc_addr[SEL_W-1:0];
          step_q    <= '0;
          ctl_out   <= '0;
          blank_req <= 1'b1;
          st_q      <= ST_BLANK;
        end
        ST_BLANK: if (t_zero) begin
          ctl_out <= step_val;
          st_q    <= ST_SETTLE;
        end
        ST_SETTLE: if (t_zero) begin
          ctl_out <= step_val | STB_MASK;
          st_q    <= ST_STRB;
        end
        ST_STRB: begin
          if (step_q == LAST_IDX) begin
            ctl_out <= ctl_out & ~STB_MASK;
            st_q    <= ST_POST;
          end else begin
            step_q  <= step_idx;
            ctl_out <= step_val;
            st_q    <= ST_SETTLE;
          end
        end
        ST_POST: if (t_zero) begin
          blank_req <= 1'b0;
          ctl_out   <= orig_q | STB_MASK;
          st_q      <= ST_FINAL;
        end
        ST_FINAL: if (t_zero) begin
          ctl_out <= CTL_W'(sel_q) | STB_MASK;
          done    <= 1'b1;
          st_q    <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clksyn_checker.sv
module clksyn_checker #(
  parameter int CTL_W   = 8,
  parameter int STB_BIT = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             accept,
  input logic             busy,
  input logic [CTL_W-1:0] cap,
  input logic [CTL_W-1:0] ctl_out,
  input logic             blank_req,
  input logic             done
);
  localparam logic [CTL_W-1:0] SM = CTL_W'(1) << STB_BIT;

  AST_START_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (blank_req && ctl_out == '0)); // R2

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_req && ctl_out[STB_BIT]) |=> !ctl_out[STB_BIT]); // R3

  AST_STROBE_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_req && ctl_out[STB_BIT]) |-> ((ctl_out & ~SM) == $past(ctl_out))); // R3

  AST_RESTORE_STROBED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blank_req) |-> ctl_out[STB_BIT]); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!blank_req && ctl_out[STB_BIT])); // R9

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(cap)); // R10
endmodule

bind clksyn_prog clksyn_checker #(.CTL_W(CTL_W), .STB_BIT(STB_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .accept(start_acc), .busy(busy_w),
  .cap(orig_q), .ctl_out(ctl_out), .blank_req(blank_req), .done(done)
);

// File: tb/clksyn_prog_test.sv
module clksyn_prog_test;
  localparam int B = 40, S = 3, P = 10, F = 20;
  localparam int NST = 44;
  localparam int TOTAL = (B + S) + NST + (NST - 1) * S + P + F + 1;
  localparam int TAIL = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  loc_addr = '0;
  logic [12:0] prog_word = '0;
  logic [7:0]  ctl_in = '0;
  logic [7:0]  ctl_out;
  logic        blank_req, done;

  int n_checks = 0, n_fail = 0, cyc = 0;

  logic [7:0] e_ctl [0:TOTAL+TAIL];
  logic       e_blk [0:TOTAL+TAIL];
  logic       e_dn  [0:TOTAL+TAIL];
  string      e_tag [0:TOTAL+TAIL];

  always #4 clk = ~clk;

  clksyn_prog #(
    .CLK_HZ(1000000), .BLANK_US(B), .SETTLE_US(S), .POST_US(P), .FINAL_US(F)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .loc_addr(loc_addr),
    .prog_word(prog_word), .ctl_in(ctl_in), .ctl_out(ctl_out),
    .blank_req(blank_req), .done(done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: run hung, cycles %0d expected < 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  // frame bit i: 1, 0, 0 (write), loc LSB first, word LSB first  (R5)
  function automatic logic fbit(input int i, input logic [4:0] l, input logic [12:0] w);
    if (i == 0) return 1'b1;
    if (i < 3)  return 1'b0;
    if (i < 8)  return l[i-3];
    return w[i-8];
  endfunction

  // port value of strobe number k  (R4, R6)
  function automatic logic [7:0] sval(input int k, input logic [4:0] l, input logic [12:0] w);
    int j;
    if (k == 0) return 8'h00;
    if (k == 1) return 8'h01;
    j = k - 2;
    return 8'h01 | (8'(fbit(j / 2, l, w)) << 2) | (8'(j % 2) << 3);
  endfunction

  task automatic put(inout int n, input logic [7:0] c, input logic b, input logic d, input string t);
    e_ctl[n] = c; e_blk[n] = b; e_dn[n] = d; e_tag[n] = t;
    n++;
  endtask

  task automatic build(input logic [4:0] l, input logic [12:0] w, input logic [7:0] o);
    int n = 0;
    for (int i = 0; i < B + S; i++) put(n, 8'h00, 1'b1, 1'b0, "R2");
    for (int k = 0; k < NST; k++) begin
      put(n, sval(k, l, w) | 8'h40, 1'b1, 1'b0, (k < 2) ? "R4 R3" : "R5 R6 R3");
      if (k < NST - 1)
        for (int s = 0; s < S; s++) put(n, sval(k + 1, l, w), 1'b1, 1'b0, "R3");
    end
    for (int i = 0; i < P; i++) put(n, sval(NST - 1, l, w), 1'b1, 1'b0, "R7");
    for (int i = 0; i < F; i++) put(n, o | 8'h40, 1'b0, 1'b0, "R8");
    put(n, {4'b0, l[3:0]} | 8'h40, 1'b0, 1'b1, "R9");
    for (int i = 0; i < TAIL; i++) put(n, {4'b0, l[3:0]} | 8'h40, 1'b0, 1'b0, "R9");
  endtask

  task automatic run(input logic [4:0] l, input logic [12:0] w, input logic [7:0] o, input int inj);
    build(l, w, o);
    loc_addr = l; prog_word = w; ctl_in = o; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < TOTAL + TAIL; n++) begin
      n_checks++;
      if (ctl_out !== e_ctl[n] || blank_req !== e_blk[n] || done !== e_dn[n]) begin
        n_fail++;
        $display("FAIL %s%s: sample %0d ctl=%h blank=%b done=%b expected ctl=%h blank=%b done=%b",
                 e_tag[n], (inj >= 0) ? " R10" : "", n, ctl_out, blank_req, done,
                 e_ctl[n], e_blk[n], e_dn[n]);
      end
      // R10: a start mid-sequence with other inputs; R8: ctl_in wanders after capture
      if (n == inj) begin
        start = 1'b1; loc_addr = 5'($urandom); prog_word = 13'($urandom);
      end else start = 1'b0;
      ctl_in = 8'($urandom);
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    n_checks++;
    if (ctl_out !== 8'h00 || blank_req !== 1'b0 || done !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: ctl=%h blank=%b done=%b expected ctl=00 blank=0 done=0",
               ctl_out, blank_req, done);
    end
    rst_n = 1'b1;
    @(negedge clk);
    run(5'h00, 13'h0000, 8'h00, -1);
    run(5'h1F, 13'h1FFF, 8'hFF, 20);
    run(5'h15, 13'h0AAA, 8'h3C, 100);
    run(5'h0A, 13'h1555, 8'h81, TOTAL - 2);
    for (int r = 0; r < 12; r++)
      run(5'($urandom), 13'($urandom), 8'($urandom), int'($urandom % (TOTAL - 1)));
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule